// File: doc/BRIEF.md
# Clock Stretching Phase Generator

This block turns a master oscillator into the phase-2 clock of a CPU bus. Each bus cycle runs at one of two speeds. A fast cycle lasts two master clocks. A slow cycle lasts eight master clocks by default, which gives a slow device four times as long to answer. With a 32 MHz master, the bus runs at 16 MHz for fast cycles and 4 MHz for slow ones.

Several active-high slow-device selects are combined into one stretch request. That request is sampled once per bus cycle, on the last master clock of the cycle. One reloadable phase counter produces both cycle lengths. When the counter reaches its terminal count, it reloads synchronously from one of two presets. In both kinds of cycle, phase-2 is low for the first half and high for the second half.

Besides phase-2, the block drives two more outputs. The terminal-count flag marks the last master period before phase-2 falls. The cycle-end strobe marks the master period that follows each fall of phase-2. Downstream logic can use these two outputs to tell a real bus cycle apart from the filler clocks inside a stretched cycle.

Top module: `clk_stretch_gen`

## Requirements
- R1: `rst` is synchronous and active high. The master edge that samples it high leaves `phi2`, `tc` and `cyc_end` at 0, with the counter at the start of the low phase of a fast cycle. The first cycle after reset is a fast cycle, so `phi2` rises one master clock after the last reset edge.
- R2: A fast cycle lasts 2 master clocks: `phi2` is low for 1 clock, then high for 1 clock.
- R3: A slow cycle lasts 2^CNT_W master clocks (8 by default): `phi2` is low for the first half and high for the second half.
- R4: The stretch request is sampled only on the master edge that ends a cycle, which is the edge taken while `tc` is 1. That sample sets the length of the next cycle. Changes to `slow_sel` at any other edge do not affect the current cycle or the next one.
- R5: The request is the OR of all bits of `slow_sel`, each bit active high. Any single bit set at the sampling edge gives a slow cycle. All bits at 0 give a fast cycle.
- R6: `tc` is 1 exactly during the final master period of each cycle, which is always a period with `phi2` high.
- R7: `cyc_end` is 1 for exactly one master period, the one right after each falling edge of `phi2`. It stays 0 at every other time, including the period right after reset.
- R8: Every low phase of `phi2` is followed by a high phase of the same length: long after long, short after short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator clock, running at twice the fast bus rate |
| rst | input | 1 | Synchronous reset, active high |
| slow_sel | input | NUM_SEL | Active-high slow-device selects, combined by OR into the stretch request |
| phi2 | output | 1 | Phase-2 bus clock, registered |
| tc | output | 1 | Terminal count: high during the last master period of a cycle |
| cyc_end | output | 1 | One-master-clock strobe right after each falling edge of phi2 |

## Verification
Three things happen on the same master edge: the counter reloads, the stretch request is sampled, and `cyc_end` is raised. So on one edge the strobe for the cycle just finished must appear while the length of the next cycle is being chosen. The bench provokes this by changing `slow_sel` on that exact edge, and separately on every other edge of a cycle, using random selects and directed patterns. It then judges `phi2`, `tc` and `cyc_end` against a cycle-position model in the bench. A second collision is a reset that arrives in the middle of a stretched cycle. That case is judged by checking for a fresh fast cycle with no `cyc_end` pulse.

// File: rtl/clk_stretch_pkg.sv
package clk_stretch_pkg;

  // Kind of bus cycle currently in progress.
  typedef enum logic {
    CYC_FAST = 1'b0,
    CYC_SLOW = 1'b1
  } cyc_kind_e;

endpackage

// File: rtl/stretch_req_merge.sv
module stretch_req_merge #(
  parameter int NUM_SEL = 4
) (
  input  logic [NUM_SEL-1:0] sel,
  output logic               req
);
  // Build an OR chain so that any slow device can ask for a stretch.
  logic [NUM_SEL:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_or
    assign chain[i+1] = chain[i] | sel[i];
  end
  assign req = chain[NUM_SEL];
endmodule

// File: rtl/phase_counter.sv
module phase_counter
  import clk_stretch_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output cyc_kind_e        kind_d,
  output logic             at_end
);
  // A fast cycle starts with all upper bits set, so it has only two states.
  // A slow cycle starts at zero and runs through every state.
  localparam logic [CNT_W-1:0] FAST_PRESET = {{(CNT_W-1){1'b1}}, 1'b0};
  localparam logic [CNT_W-1:0] SLOW_PRESET = '0;

  cyc_kind_e kind_q;

  assign at_end = &cnt_q;

  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    kind_d = kind_q;
    if (rst) begin
      cnt_d  = FAST_PRESET;
      kind_d = CYC_FAST;
    end else if (at_end) begin
      cnt_d  = req ? SLOW_PRESET : FAST_PRESET;
      kind_d = req ? CYC_SLOW : CYC_FAST;
    end
  end

  always_ff @(posedge clk) begin
    cnt_q  <= cnt_d;
    kind_q <= kind_d;
  end
endmodule

// File: rtl/phase_decode.sv
module phase_decode
  import clk_stretch_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_d,
  input  cyc_kind_e        kind_d,
  input  logic             at_end,
  output logic             phi2,
  output logic             tc,
  output logic             cyc_end
);
  // The outputs are decoded from next-state values and then registered,
  // so each one leaves a flop and cannot glitch.
  logic phi2_n;
  assign phi2_n = (kind_d == CYC_SLOW) ? cnt_d[CNT_W-1] : cnt_d[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phi2    <= 1'b0;
      tc      <= 1'b0;
      cyc_end <= 1'b0;
    end else begin
      phi2    <= phi2_n;
      tc      <= &cnt_d;
      cyc_end <= at_end;
    end
  end
endmodule

// File: rtl/clk_stretch_gen.sv
module clk_stretch_gen
  import clk_stretch_pkg::*;
#(
  parameter int NUM_SEL = 4,
  parameter int CNT_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SEL-1:0] slow_sel,
  output logic               phi2,
  output logic               tc,
  output logic               cyc_end
);
  logic             req;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  cyc_kind_e        kind_d;
  logic             at_end;

  stretch_req_merge #(.NUM_SEL(NUM_SEL)) u_merge (
    .sel (slow_sel),
    .req (req)
  );

  phase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .cnt_q  (cnt_q),
    .cnt_d  (cnt_d),
    .kind_d (kind_d),
    .at_end (at_end)
  );

  phase_decode #(.CNT_W(CNT_W)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .cnt_d   (cnt_d),
    .kind_d  (kind_d),
    .at_end  (at_end),
    .phi2    (phi2),
    .tc      (tc),
    .cyc_end (cyc_end)
  );
endmodule

// File: rtl/clk_stretch_checker.sv
module clk_stretch_checker #(
  parameter int NUM_SEL = 4,
  parameter int CNT_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SEL-1:0] slow_sel,
  input logic               phi2,
  input logic               tc,
  input logic               cyc_end
);
  localparam int HALF = 1 << (CNT_W - 1);

  logic prev_phi2;
  logic was_rst;
  logic pend_slow;
  int   run_len;
  int   low_len;

  // Track how long phi2 has held its level, and the request taken at the sampling edge.
  always_ff @(posedge clk) begin
    was_rst <= rst;
    if (rst) begin
      prev_phi2 <= 1'b0;
      run_len   <= 0;
      low_len   <= 0;
      pend_slow <= 1'b0;
    end else begin
      prev_phi2 <= phi2;
      if (phi2 != prev_phi2) run_len <= 1;
      else                   run_len <= run_len + 1;
      if (phi2 && !prev_phi2) low_len <= run_len;
      if (tc) pend_slow <= |slow_sel;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    was_rst |-> (!phi2 && !tc && !cyc_end));

  // R2 and R3: every phase lasts either one master clock or half of a slow cycle.
  a_r3_phase_length: assert property (@(posedge clk) disable iff (rst)
    (phi2 != prev_phi2) |-> (run_len == 1 || run_len == HALF));

  a_r4_sampled_length: assert property (@(posedge clk) disable iff (rst)
    (phi2 && !prev_phi2) |-> (run_len == (pend_slow ? HALF : 1)));

  a_r6_tc_in_high: assert property (@(posedge clk) disable iff (rst)
    tc |-> phi2);

  a_r6_tc_before_fall: assert property (@(posedge clk) disable iff (rst)
    (prev_phi2 && !phi2) |-> $past(tc));

  a_r7_strobe_after_fall: assert property (@(posedge clk) disable iff (rst)
    cyc_end |-> (prev_phi2 && !phi2));

  a_r7_fall_gives_strobe: assert property (@(posedge clk) disable iff (rst)
    (prev_phi2 && !phi2) |-> cyc_end);

  a_r8_equal_halves: assert property (@(posedge clk) disable iff (rst)
    (prev_phi2 && !phi2) |-> (run_len == low_len));
endmodule

bind clk_stretch_gen clk_stretch_checker #(.NUM_SEL(NUM_SEL), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .slow_sel (slow_sel),
  .phi2     (phi2),
  .tc       (tc),
  .cyc_end  (cyc_end)
);

// File: tb/test_clk_stretch_gen.sv
`timescale 1ns/100ps
module test_clk_stretch_gen;
  localparam int NS = 4;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] slow_sel = '0;
  logic          phi2, tc, cyc_end;

  int n_chk = 0;
  int n_err = 0;

  // Model state, updated only from the requirements.
  bit m_valid = 0;
  int m_pos   = 0;
  bit m_slow  = 0;
  bit m_fresh = 1;

  // Phase run tracking for R8.
  bit t_prev = 0;
  int t_run  = 0;
  int t_low  = -1;

  always #2.5 clk = ~clk;

  clk_stretch_gen #(.NUM_SEL(NS), .CNT_W(CW)) i_clk_stretch_gen (
    .clk      (clk),
    .rst      (rst),
    .slow_sel (slow_sel),
    .phi2     (phi2),
    .tc       (tc),
    .cyc_end  (cyc_end)
  );

  function automatic int cyc_len(bit slow);
    return slow ? (1 << CW) : 2;
  endfunction

  function automatic bit exp_phi2(int pos, bit slow);
    return pos >= cyc_len(slow) / 2;
  endfunction

  function automatic bit exp_tc(int pos, bit slow);
    return pos == cyc_len(slow) - 1;
  endfunction

  function automatic bit exp_end(int pos, bit fresh);
    return (pos == 0) && !fresh;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Check the outputs against the model, then drive the inputs for the next master edge.
  task automatic step(input logic [NS-1:0] s, input logic r, input string tag);
    string ptag;
    @(negedge clk);
    if (m_valid) begin
      ptag = (tag != "") ? tag : (m_slow ? "R3" : "R2");
      if (m_fresh && m_pos == 0) begin
        chk("R1", phi2, 1'b0);
        chk("R1", tc, 1'b0);
        chk("R1", cyc_end, 1'b0);
      end else begin
        chk(ptag, phi2, exp_phi2(m_pos, m_slow));
        chk("R6", tc, exp_tc(m_pos, m_slow));
        chk("R7", cyc_end, exp_end(m_pos, m_fresh));
      end
      if (phi2 === t_prev) t_run++;
      else begin
        if (phi2 === 1'b1) t_low = t_run;
        else if (t_low >= 0) chk("R8", (t_run == t_low), 1'b1);
        t_run = 1;
      end
      t_prev = phi2;
    end
    slow_sel = s;
    rst = r;
    if (r) begin
      m_valid = 1; m_pos = 0; m_slow = 0; m_fresh = 1;
      t_prev = 0; t_run = 0; t_low = -1;
    end else if (m_pos == cyc_len(m_slow) - 1) begin
      m_pos = 0; m_slow = |s; m_fresh = 0;
    end else begin
      m_pos++;
    end
  endtask

  // Run until the current cycle reloads: end_sel on the sampling edge, other_sel before it.
  task automatic run_cycle(input logic [NS-1:0] end_sel, input logic [NS-1:0] other_sel,
                           input string tag);
    bit done = 0;
    while (!done) begin
      if (m_pos == cyc_len(m_slow) - 1) begin
        step(end_sel, 1'b0, tag);
        done = 1;
      end else begin
        step(other_sel, 1'b0, tag);
      end
    end
  endtask

  initial begin : watchdog
    #(5ns * 20000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20231));
    // R1: reset, then the first cycles must be fast.
    for (int i = 0; i < 3; i++) step('0, 1'b1, "R1");
    run_cycle('0, '0, "R2");
    run_cycle('0, '0, "R2");
    // R3: a slow cycle requested by all selects.
    run_cycle('1, '0, "R3");
    run_cycle('0, '0, "R3");
    // R4: selects toggling away from the sampling edge must not matter.
    run_cycle('0, '1, "R4");
    run_cycle('1, '1, "R4");
    run_cycle('0, '1, "R4");
    run_cycle('0, '0, "R4");
    // R5: each select on its own stretches the next cycle.
    for (int i = 0; i < NS; i++) begin
      run_cycle(NS'(1) << i, '0, "R5");
      run_cycle('0, '0, "R5");
    end
    // R1: reset in the middle of a slow cycle.
    run_cycle('1, '0, "R3");
    step('0, 1'b0, "R3");
    step('0, 1'b0, "R3");
    step('1, 1'b1, "R1");
    run_cycle('0, '1, "R1");
    // Random mix of selects and occasional resets.
    for (int i = 0; i < 600; i++) begin
      logic [NS-1:0] s;
      logic r;
      s = (($urandom % 3) == 0) ? NS'($urandom) : '0;
      r = (($urandom % 97) == 0);
      step(s, r, "");
    end
    run_cycle('0, '0, "R2");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule